// File: doc/BRIEF.md
# Decorated Store Read-Modify-Write Engine

This unit sits on a bus between a master port and a peripheral slave port. Both sides follow an AHB-Lite-style pipeline: an address phase, then a data phase, with a ready signal for back-pressure. Most transfers go straight through. A write is different when its address falls in the peripheral window (bits 31:29 equal to 3'b010) and carries an operation code in bits 28:26. The unit then replaces that write with an atomic update of the real peripheral location. It reads the old value, combines it with the write data using the chosen logic operation, and writes the result back.

The real location is the address with bits 28:20 cleared. This keeps the window tag in bits 31:29 and a 20-bit offset in bits 19:0. On the slave side, the one master write becomes a slave read followed by a slave write, with no other transfer in between. The master's data phase is stalled by one extra cycle while the write-back address phase is issued.

Back-pressure rules are as follows. The master may only treat its transfer as taken, or its data phase as finished, on a clock edge where `m_hready` is high. The slave stalls the unit by holding `s_hready` low. Whenever the slave stalls, the master is stalled too. The unit itself adds exactly one low cycle on `m_hready` per decorated write.

Top module: `deco_rmw_engine`

## Requirements
- R1: A transfer whose address is outside the window 0x4000_0000–0x5FFF_FFFF is a plain transfer. So is one whose bits 28:26 are neither 3'b001 nor 3'b010. A plain transfer reaches the slave with its address, direction, size and transfer type unchanged, and its data phase takes one cycle when the slave is ready. Out of reset, `m_hready` follows `s_hready` and the slave sees the master's idle transfer type (2'b00).
- R2: When a decorated write's address phase is accepted, the slave sees a read (`s_hwrite`=0) of the real address, which is the master address ANDed with 0xE00F_FFFF, at the master's size.
- R3: In the cycle after a decorated write is accepted, `m_hready` is low. In that same cycle the slave sees a non-sequential (2'b10) write address phase to the same real address and size.
- R4: Once the slave completes the read, the next cycle drives the combined value on `s_hwdata`, and `m_hready` follows `s_hready`. With a ready slave, a decorated write's data phase lasts exactly two cycles.
- R5: Code 3'b010 in bits 28:26 selects OR: each active byte lane is written back as old value OR write data.
- R6: Code 3'b001 in bits 28:26 selects AND: each active byte lane is written back as old value AND write data.
- R7: Address bits 25:20 affect neither the operation chosen nor the real address.
- R8: The active lanes are set by the size (0 = byte, 1 = halfword, 2 = word) and the low address bits. A byte uses the lane given by bits 1:0, and a halfword uses lanes 1:0 or 3:2 according to bit 1. Write data for a byte or halfword arrives replicated on all lanes. Inactive lanes of the write-back data carry the old read value.
- R9: A read to a decorated address is a plain read of the real address, and it returns the slave data unchanged.
- R10: While `s_hready` is low, `m_hready` is low. A stalled slave delays every phase of the update without changing its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| m_haddr | input | 32 | Master address |
| m_htrans | input | 2 | Master transfer type (bit 1 = active) |
| m_hwrite | input | 1 | Master direction, 1 = write |
| m_hsize | input | 3 | Master transfer size |
| m_hwdata | input | 32 | Master write data (data phase) |
| m_hready | output | 1 | Ready to master; phase ends on a high edge |
| m_hrdata | output | 32 | Read data to master |
| s_haddr | output | 32 | Slave address |
| s_htrans | output | 2 | Slave transfer type |
| s_hwrite | output | 1 | Slave direction |
| s_hsize | output | 3 | Slave transfer size |
| s_hwdata | output | 32 | Slave write data |
| s_hready | input | 1 | Slave ready |
| s_hrdata | input | 32 | Slave read data |

## Verification
The properties assume that the master keeps its address-phase signals stable while `m_hready` is low. They also assume that write data for a byte or halfword is replicated across the lanes. The master model in the bench drives one transfer at a time and holds its signals until the accepting edge, so both assumptions hold. The checks on the write-back cycle rely on a slave that returns read data in the data phase it completes. The bench slave is a simple memory that meets this. It can insert stall cycles, and its stall pattern only changes at clock edges.

// File: rtl/deco_rmw_pkg.sv
package deco_rmw_pkg;

  typedef enum logic [1:0] {
    ST_PASS  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WBACK = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_AND  = 2'd1,
    OP_OR   = 2'd2
  } rmw_op_e;

  localparam logic [1:0] TRANS_IDLE   = 2'b00;
  localparam logic [1:0] TRANS_NONSEQ = 2'b10;

  function automatic logic [7:0] lane_combine(rmw_op_e op, logic [7:0] old_b, logic [7:0] new_b);
    case (op)
      OP_AND:  return old_b & new_b;
      OP_OR:   return old_b | new_b;
      default: return old_b;
    endcase
  endfunction

endpackage

// File: rtl/deco_addr_decode.sv
module deco_addr_decode
  import deco_rmw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int REGION_W = 3,
  parameter logic [REGION_W-1:0] REGION_TAG = 3'b010,
  parameter int OP_LSB   = 26,
  parameter int OP_W     = 3,
  parameter int OFFSET_W = 20,
  parameter logic [OP_W-1:0] AND_CODE = 3'b001,
  parameter logic [OP_W-1:0] OR_CODE  = 3'b010
) (
  input  logic [ADDR_W-1:0] addr,
  output rmw_op_e           op,
  output logic [ADDR_W-1:0] real_addr
);
  localparam logic [ADDR_W-1:0] HI_KEEP = {ADDR_W{1'b1}} << (ADDR_W - REGION_W);
  localparam logic [ADDR_W-1:0] LO_KEEP = {ADDR_W{1'b1}} >> (ADDR_W - OFFSET_W);
  localparam logic [ADDR_W-1:0] KEEP    = HI_KEEP | LO_KEEP;

  logic            in_window;
  logic [OP_W-1:0] code;

  assign in_window = (addr[ADDR_W-1 -: REGION_W] == REGION_TAG);
  assign code      = addr[OP_LSB +: OP_W];

  always_comb begin
    op = OP_NONE;
    if (in_window) begin
      if (code == AND_CODE)     op = OP_AND;
      else if (code == OR_CODE) op = OP_OR;
    end
  end

  assign real_addr = (op != OP_NONE) ? (addr & KEEP) : addr;

endmodule

// File: rtl/deco_lane_alu.sv
module deco_lane_alu
  import deco_rmw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  rmw_op_e                       op,
  input  logic [2:0]                    size,
  input  logic [$clog2(DATA_W/8)-1:0]   lane_sel,
  input  logic [DATA_W-1:0]             old_data,
  input  logic [DATA_W-1:0]             new_data,
  output logic [DATA_W-1:0]             result
);
  localparam int LANES  = DATA_W / 8;
  localparam int LIDX_W = $clog2(LANES);

  logic [LANES-1:0] lane_on;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_on[i] = ((LIDX_W'(i) >> size) == (lane_sel >> size));
    assign result[8*i +: 8] = lane_on[i]
                              ? lane_combine(op, old_data[8*i +: 8], new_data[8*i +: 8])
                              : old_data[8*i +: 8];
  end

endmodule

// File: rtl/deco_seq.sv
module deco_seq
  import deco_rmw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ap_taken,
  input  logic       deco_wr,
  input  logic       s_hready,
  output seq_state_e state,
  output logic       take,
  output logic       fetch_done
);
  seq_state_e nxt;

  assign take       = ap_taken && deco_wr;
  assign fetch_done = (state == ST_FETCH) && s_hready;

  always_comb begin
    nxt = state;
    case (state)
      ST_PASS:  if (take) nxt = ST_FETCH;
      ST_FETCH: if (s_hready) nxt = ST_WBACK;
      ST_WBACK: if (s_hready) nxt = take ? ST_FETCH : ST_PASS;
      default:  nxt = ST_PASS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_PASS;
    else        state <= nxt;
  end

endmodule

// File: rtl/deco_rmw_engine.sv
module deco_rmw_engine
  import deco_rmw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int OP_LSB   = 26,
  parameter int OFFSET_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] m_haddr,
  input  logic [1:0]        m_htrans,
  input  logic              m_hwrite,
  input  logic [2:0]        m_hsize,
  input  logic [DATA_W-1:0] m_hwdata,
  output logic              m_hready,
  output logic [DATA_W-1:0] m_hrdata,
  output logic [ADDR_W-1:0] s_haddr,
  output logic [1:0]        s_htrans,
  output logic              s_hwrite,
  output logic [2:0]        s_hsize,
  output logic [DATA_W-1:0] s_hwdata,
  input  logic              s_hready,
  input  logic [DATA_W-1:0] s_hrdata
);
  localparam int LIDX_W = $clog2(DATA_W / 8);

  rmw_op_e           ap_op;
  logic [ADDR_W-1:0] ap_real;
  seq_state_e        state;
  logic              take, fetch_done;
  logic              in_rd, in_wb;

  logic [ADDR_W-1:0] ctx_addr;
  logic [2:0]        ctx_size;
  rmw_op_e           ctx_op;
  logic [DATA_W-1:0] combined, res_q;

  deco_addr_decode #(
    .ADDR_W  (ADDR_W),
    .OP_LSB  (OP_LSB),
    .OFFSET_W(OFFSET_W)
  ) u_dec (
    .addr     (m_haddr),
    .op       (ap_op),
    .real_addr(ap_real)
  );

  deco_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ap_taken  (m_htrans[1] && m_hready),
    .deco_wr   ((ap_op != OP_NONE) && m_hwrite),
    .s_hready  (s_hready),
    .state     (state),
    .take      (take),
    .fetch_done(fetch_done)
  );

  assign in_rd = (state == ST_FETCH);
  assign in_wb = (state == ST_WBACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_addr <= '0;
      ctx_size <= '0;
      ctx_op   <= OP_NONE;
    end else if (take) begin
      ctx_addr <= ap_real;
      ctx_size <= m_hsize;
      ctx_op   <= ap_op;
    end
  end

  deco_lane_alu #(.DATA_W(DATA_W)) u_alu (
    .op      (ctx_op),
    .size    (ctx_size),
    .lane_sel(ctx_addr[LIDX_W-1:0]),
    .old_data(s_hrdata),
    .new_data(m_hwdata),
    .result  (combined)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          res_q <= '0;
    else if (fetch_done) res_q <= combined;
  end

  // address phase toward the slave
  always_comb begin
    if (in_rd) begin
      s_haddr  = ctx_addr;
      s_htrans = TRANS_NONSEQ;
      s_hwrite = 1'b1;
      s_hsize  = ctx_size;
    end else begin
      s_haddr  = ap_real;
      s_htrans = m_htrans;
      s_hwrite = m_hwrite && (ap_op == OP_NONE);
      s_hsize  = m_hsize;
    end
  end

  assign s_hwdata = in_wb ? res_q : m_hwdata;
  assign m_hrdata = s_hrdata;
  assign m_hready = in_rd ? 1'b0 : s_hready;

endmodule

// File: rtl/deco_rmw_chk.sv
module deco_rmw_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] m_haddr,
  input logic [1:0]        m_htrans,
  input logic              m_hwrite,
  input logic              m_hready,
  input logic [ADDR_W-1:0] s_haddr,
  input logic [1:0]        s_htrans,
  input logic              s_hwrite,
  input logic              s_hready,
  input logic              in_rd,
  input logic              in_wb
);
  localparam logic [ADDR_W-1:0] REAL_MASK = 32'hE00F_FFFF;

  logic hit;
  assign hit = (m_haddr[31:29] == 3'b010) &&
               ((m_haddr[28:26] == 3'b001) || (m_haddr[28:26] == 3'b010));

  assert_plain_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_rd && !hit) |-> (s_haddr == m_haddr && s_hwrite == m_hwrite && s_htrans == m_htrans));

  assert_fetch_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_rd && hit) |-> (s_haddr == (m_haddr & REAL_MASK) && !s_hwrite));

  assert_wback_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_htrans[1] && m_hwrite && m_hready && hit) |=>
      (!m_hready && s_hwrite && s_htrans == 2'b10 && s_haddr == $past(m_haddr & REAL_MASK)));

  assert_fetch_to_wback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rd && s_hready) |=> (in_wb && m_hready == s_hready));

  assert_stall_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !s_hready |-> !m_hready);

endmodule

bind deco_rmw_engine deco_rmw_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .m_haddr (m_haddr),
  .m_htrans(m_htrans),
  .m_hwrite(m_hwrite),
  .m_hready(m_hready),
  .s_haddr (s_haddr),
  .s_htrans(s_htrans),
  .s_hwrite(s_hwrite),
  .s_hready(s_hready),
  .in_rd   (in_rd),
  .in_wb   (in_wb)
);

// File: tb/tb_deco_rmw_engine.sv
module tb_deco_rmw_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] m_haddr, m_hwdata, m_hrdata;
  logic [1:0]  m_htrans;
  logic        m_hwrite, m_hready;
  logic [2:0]  m_hsize;
  logic [31:0] s_haddr, s_hwdata, s_hrdata;
  logic [1:0]  s_htrans;
  logic        s_hwrite;
  logic [2:0]  s_hsize;
  logic        s_hready_r;

  int total = 0, bad = 0;
  bit stall_mode = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  deco_rmw_engine dut (
    .clk(clk), .rst_n(rst_n),
    .m_haddr(m_haddr), .m_htrans(m_htrans), .m_hwrite(m_hwrite), .m_hsize(m_hsize),
    .m_hwdata(m_hwdata), .m_hready(m_hready), .m_hrdata(m_hrdata),
    .s_haddr(s_haddr), .s_htrans(s_htrans), .s_hwrite(s_hwrite), .s_hsize(s_hsize),
    .s_hwdata(s_hwdata), .s_hready(s_hready_r), .s_hrdata(s_hrdata)
  );

  // ---------------- slave memory model ----------------
  logic [31:0] mem    [128];
  logic [31:0] mirror [128];
  logic        dp_v, dp_w;
  logic [31:0] dp_a;
  logic [2:0]  dp_sz;
  int          cyc;

  function automatic logic [6:0] idx(input logic [31:0] a);
    return {a[31:29], a[5:2]};
  endfunction

  function automatic logic [3:0] lanes(input logic [31:0] a, input logic [2:0] sz);
    case (sz)
      3'd0:    return 4'b0001 << a[1:0];
      3'd1:    return a[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      dp_v <= 1'b0; dp_w <= 1'b0; dp_a <= '0; dp_sz <= '0;
      s_hready_r <= 1'b1; cyc <= 0;
      for (int k = 0; k < 128; k++) mem[k] <= '0;
    end else begin
      cyc <= cyc + 1;
      if (s_hready_r) begin
        if (dp_v && dp_w)
          for (int k = 0; k < 4; k++)
            if (lanes(dp_a, dp_sz)[k]) mem[idx(dp_a)][8*k +: 8] <= s_hwdata[8*k +: 8];
        dp_v  <= s_htrans[1];
        dp_w  <= s_hwrite;
        dp_a  <= s_haddr;
        dp_sz <= s_hsize;
      end
      s_hready_r <= !(stall_mode && (cyc % 3 != 0));
    end
  end

  assign s_hrdata = mem[idx(dp_a)];

  // ---------------- checking helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // one transfer; called and returns one time unit after a falling edge
  task automatic xfer(input logic [31:0] a, input logic wr, input logic [2:0] sz,
                      input logic [31:0] wd);
    logic        deco, is_or, rdy;
    logic [31:0] sa, old, expw, keep, rd, sw;
    logic [3:0]  ln;
    logic [6:0]  ix;
    int          ncyc;
    bit          first;
    deco  = (a[31:29] == 3'b010) && (a[28:26] == 3'b001 || a[28:26] == 3'b010);
    is_or = (a[28:26] == 3'b010);
    sa    = deco ? (a & 32'hE00F_FFFF) : a;
    ix    = idx(sa);
    ln    = lanes(a, sz);
    old   = mirror[ix];
    keep  = {{8{ln[3]}}, {8{ln[2]}}, {8{ln[1]}}, {8{ln[0]}}};
    expw  = (old & ~keep) | ((is_or ? (old | wd) : (old & wd)) & keep);

    m_haddr = a; m_htrans = 2'b10; m_hwrite = wr; m_hsize = sz;
    #1;
    check(s_haddr == sa, deco ? (wr ? "R2 R7" : "R9") : "R1", "slave address", s_haddr, sa);
    check(s_hwrite == (wr && !deco), deco ? (wr ? "R2" : "R9") : "R1", "slave direction",
          32'(s_hwrite), 32'(wr && !deco));
    check(s_hsize == sz, deco ? "R2" : "R1", "slave size", 32'(s_hsize), 32'(sz));
    do begin
      rdy = m_hready;
      if (!s_hready_r) check(!m_hready, "R10", "ready while slave stalls", 32'(m_hready), 0);
      @(negedge clk); #1;
    end while (!rdy);

    m_htrans = 2'b00; m_hwdata = wd;
    #1;
    first = 1; ncyc = 0;
    do begin
      if (deco && wr && first) begin
        check(!m_hready, "R3", "master ready in fetch cycle", 32'(m_hready), 0);
        check(s_hwrite && s_htrans == 2'b10, "R3", "write-back address phase",
              {29'd0, s_hwrite, s_htrans}, 32'h6);
        check(s_haddr == sa, "R3", "write-back address", s_haddr, sa);
      end
      first = 0;
      rdy = m_hready; rd = m_hrdata; sw = s_hwdata;
      if (!s_hready_r) check(!m_hready, "R10", "ready while slave stalls", 32'(m_hready), 0);
      ncyc++;
      @(negedge clk); #1;
    end while (!rdy);

    if (deco && wr) begin
      check((sw & keep) == (expw & keep), is_or ? "R5" : "R6", "combined lanes", sw & keep, expw & keep);
      check((sw & ~keep) == (old & ~keep), "R8", "inactive lanes", sw & ~keep, old & ~keep);
      if (!stall_mode) check(ncyc == 2, "R4", "decorated data phase cycles", ncyc, 2);
      mirror[ix] = expw;
    end else if (wr) begin
      if (!stall_mode) check(ncyc == 1, "R1", "plain data phase cycles", ncyc, 1);
      mirror[ix] = (old & ~keep) | (wd & keep);
    end else begin
      check(rd == old, deco ? "R9" : "R1", "read data", rd, old);
    end
  endtask

  function automatic logic [31:0] rep(input logic [2:0] sz, input logic [7:0] b);
    case (sz)
      3'd0:    return {4{b}};
      3'd1:    return {2{b, ~b}};
      default: return {b, ~b, b ^ 8'h3C, 8'h81 ^ b};
    endcase
  endfunction

  task automatic sweep(input int rounds);
    for (int opi = 0; opi < 2; opi++)
      for (int sz = 0; sz < 3; sz++)
        for (int off = 0; off < 4; off += (1 << sz))
          for (int p = 0; p < rounds; p++) begin
            logic [31:0] a;
            logic [7:0]  b;
            int          w;
            w = (p + off + sz) % 8;
            b = 8'hA5 ^ 8'(p * 8'h37) ^ 8'(off) ^ 8'(opi * 8'h5A);
            a = 32'h4000_0000 | (32'(opi + 1) << 26) | (32'((p * 13 + sz + off) & 63) << 20)
                | (32'(w) << 2) | 32'(off);
            xfer(a, 1'b1, 3'(sz), rep(3'(sz), b));
          end
  endtask

  task automatic readback();
    for (int w = 0; w < 8; w++) xfer(32'h4000_0000 | (32'(w) << 2), 1'b0, 3'd2, '0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    for (int k = 0; k < 128; k++) mirror[k] = '0;
    rst_n = 1'b0; m_haddr = '0; m_htrans = 2'b00; m_hwrite = 1'b0; m_hsize = 3'd2; m_hwdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(m_hready == 1'b1, "R1", "reset ready", 32'(m_hready), 1);
    check(s_htrans == 2'b00, "R1", "reset idle transfer", 32'(s_htrans), 0);

    for (int w = 0; w < 8; w++)
      xfer(32'h4000_0000 | (32'(w) << 2), 1'b1, 3'd2, (32'(w) * 32'h1111_1111) ^ 32'h5A3C_9600);
    readback();

    // R5 R6 R7 R8: all ops, sizes and lane offsets
    sweep(4);
    readback();

    // R1: other codes inside the window, and decorated codes outside it
    for (int c = 0; c < 8; c++) begin
      if (c == 1 || c == 2) continue;
      xfer(32'h4000_0000 | (32'(c) << 26) | (32'(c) << 20) | (32'(c % 8) << 2), 1'b1, 3'd2,
           32'hC0DE_0000 | 32'(c));
      xfer(32'h4000_0000 | (32'(c) << 26) | (32'(c % 8) << 2), 1'b0, 3'd2, '0);
    end
    for (int c = 1; c < 3; c++) begin
      xfer(32'h6000_0000 | (32'(c) << 26) | (32'(c) << 2), 1'b1, 3'd2, 32'hFACE_0000 | 32'(c));
      xfer(32'h6000_0000 | (32'(c) << 26) | (32'(c) << 2), 1'b0, 3'd2, '0);
      xfer(32'h2000_0000 | (32'(c) << 26) | (32'(c) << 2), 1'b1, 3'd2, 32'hBEEF_0000 | 32'(c));
    end

    // R9: loads to decorated addresses are plain reads of the real address
    for (int w = 0; w < 8; w++)
      xfer(32'h4000_0000 | (32'((w % 2) + 1) << 26) | (32'(w * 7 % 64) << 20) | (32'(w) << 2),
           1'b0, 3'd2, '0);
    readback();

    // R10: the same sweep under slave stalls
    stall_mode = 1;
    @(negedge clk); #1;
    sweep(2);
    readback();
    stall_mode = 0;
    @(negedge clk); #1;
    readback();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule